// File: doc/BRIEF.md
# I2C Target Controller with Host-Gated Acknowledge

This block is the target (slave) side of an I2C port. It watches the SCL and SDA lines through a synchroniser running on the system clock. It finds START and STOP conditions and shifts in address and data bytes. It answers to its own 7-bit or 10-bit address and, when enabled, to the General Call address or the START byte. It drives the bus only through two active-high pull-down enables: `scl_oe` and `sda_oe`.

In automatic mode the block decides the acknowledge itself. A byte is acknowledged when it is addressed and the host's NAK control bit is clear. In interactive mode every received byte causes two things: a receive interrupt, and SCL held low in that byte's acknowledge slot. The hold lasts until the host writes the control register. The NAK bit written at that moment is the level placed on SDA in the slot.

The host reaches the block through a small register port:
- a mode register: operating mode, interactive-mode and general-call enables, and address bits 9:8;
- an own-address register;
- a control register: the NAK bit;
- a read-only status register;
- a last-received-byte register.

Top module: `i2c_tgt_ctrl`

## Requirements
- R1: After reset, MODE, OWN and CTRL all read 0. STATUS reads 0, and `scl_oe`, `sda_oe` and `rx_irq` are low.
- R2: In a 7-bit mode with NAK=0, a first byte whose bits [7:1] equal OWN[6:0] is acknowledged. Acknowledging means SDA is pulled low during the ninth clock. Each following data byte is acknowledged, is stored in RXDATA (offset 4), and gives one `rx_irq` pulse.
- R3: A first byte that matches no enabled address is not acknowledged. Nor are any later bytes until the next START. No `rx_irq` pulse is given for them.
- R4: In automatic mode with NAK=1 (CTRL bit 0), neither a matching address nor data is acknowledged.
- R5: MODE[0]=1 selects 10-bit addressing, which takes two bytes:
  - The first byte 11110, MODE[5:4], R/W=0 is acknowledged only when its bits [2:1] equal MODE[5:4].
  - The second byte must then equal OWN[7:0] to be acknowledged, and data follows.
- R6: In 7-bit modes (MODE[0]=0), MODE[5:4] has no effect on address matching.
- R7: First bytes 0x00 and 0x01 never match the own address. They are acknowledged only when MODE[3]=1. After such a match STATUS[1] reads 1; after an own-address match it reads 0.
- R8: A matching own 7-bit address with R/W=1 is acknowledged and sets STATUS[2]. SDA is then left released for the rest of the transfer.
- R9: With MODE[2]=1, every received byte, address or data, gives one `rx_irq` pulse and drives `scl_oe`. SCL stays held for as long as the host does not write CTRL, and STATUS[3] reads 1 meanwhile.
- R10: In interactive mode, writing CTRL bit 0 = 0 acknowledges the held byte and writing 1 refuses it.
- R11: `scl_oe` falls by the second clock edge after the CTRL write is sampled. `sda_oe` changes only while SCL is low.
- R12: A repeated START or a STOP in the middle of a byte discards that byte and releases both lines. A new address after the repeated START is decoded from its first bit.
- R13: MODE[1] has no effect on target behaviour. The master-capable modes 00 and 01 act as the target-only modes 10 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (acknowledge) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register offset: 0 MODE, 1 OWN, 2 CTRL, 3 STATUS, 4 RXDATA |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| rx_irq | output | 1 | One-cycle pulse per byte handed to the host |

## Verification
Address decoding is tried with four kinds of first byte: the own 7-bit address, the 10-bit header with right and wrong upper bits, the two general-call codes, and random bytes. These separate the matches that should be acknowledged from near misses, both with the general-call enable set and with it clear. The same transfers run with NAK set and clear, and in master-capable and target-only modes. This shows that the NAK bit gates the acknowledge and that the mode bit does not. Interactive transfers, in which the host delays its CTRL write, show that the clock hold lasts until the write and that the written bit sets the acknowledge. Bytes cut short by a repeated START or a STOP show that no stale bits are carried into the next address.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   localparam int BYTE_W = 8;
   localparam int BIT_CNT_W = 4;

   localparam int OFS_MODE   = 0;
   localparam int OFS_OWN    = 1;
   localparam int OFS_CTRL   = 2;
   localparam int OFS_STATUS = 3;
   localparam int OFS_RXDATA = 4;

   typedef enum logic [1:0] {PH_A1, PH_A2, PH_DAT} phase_t;

   typedef enum logic [2:0] {
      ST_IDLE, ST_SHIFT, ST_HOLD, ST_REL, ST_ACK, ST_SKIP
   } tgt_state_t;

   typedef struct packed {
      logic   hit;
      logic   gc;
      logic   rd;
      phase_t nxt;
   } addr_dec_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   localparam int CHAIN_W = 2 * STAGES;

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_tgt_sync: STAGES must be at least 2");
   end

   logic [CHAIN_W-1:0] chain;
   logic               scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         chain <= {chain[CHAIN_W-3:0], scl_i, sda_i};
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_s     = chain[CHAIN_W-1];
   assign sda_s     = chain[CHAIN_W-2];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_addr_match.sv
module i2c_tgt_addr_match
   import i2c_tgt_pkg::*;
(
   input  logic [BYTE_W-1:0] rx_byte,
   input  phase_t            ph,
   input  logic              ten_bit,
   input  logic              gc_en,
   input  logic [1:0]        own_hi,
   input  logic [BYTE_W-1:0] own_lo,
   output addr_dec_t         dec
);
   logic gc_pat, hdr_pat, own7, own10;

   always_comb begin
      gc_pat  = (rx_byte[7:1] == 7'd0);
      hdr_pat = (rx_byte[7:3] == 5'b11110);
      own7    = !ten_bit && (rx_byte[7:1] == own_lo[6:0]);
      own10   = ten_bit && hdr_pat && (rx_byte[2:1] == own_hi);
      dec     = '{hit: 1'b1, gc: 1'b0, rd: 1'b0, nxt: PH_DAT};
      unique case (ph)
         PH_A1: begin
            dec.gc  = gc_pat;
            dec.hit = gc_pat ? gc_en : (own7 || own10);
            dec.rd  = rx_byte[0] && !gc_pat;
            dec.nxt = (ten_bit && hdr_pat && !rx_byte[0]) ? PH_A2 : PH_DAT;
         end
         PH_A2:   dec.hit = (rx_byte == own_lo);
         default: dec.hit = 1'b1;
      endcase
   end
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
   import i2c_tgt_pkg::*;
#(
   parameter int REG_AW = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [BYTE_W-1:0] reg_wdata,
   output logic [BYTE_W-1:0] reg_rdata,
   input  logic              sts_match,
   input  logic              sts_gca,
   input  logic              sts_rd,
   input  logic              sts_hold,
   input  logic [BYTE_W-1:0] rx_last,
   output logic              ten_bit,
   output logic              irm_en,
   output logic              gc_en,
   output logic [1:0]        own_hi,
   output logic [BYTE_W-1:0] own_lo,
   output logic              nak_q,
   output logic              ctrl_wr
);
   localparam int MODE_W = 6;

   if (REG_AW < 3) begin : g_bad_aw
      $error("i2c_tgt_regs: REG_AW must be at least 3");
   end

   logic [MODE_W-1:0] mode_q;

   assign ctrl_wr = reg_wr && (reg_addr == REG_AW'(OFS_CTRL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         own_lo <= '0;
         nak_q  <= 1'b0;
      end else if (reg_wr) begin
         if (reg_addr == REG_AW'(OFS_MODE)) mode_q <= reg_wdata[MODE_W-1:0];
         if (reg_addr == REG_AW'(OFS_OWN))  own_lo <= reg_wdata;
         if (ctrl_wr)                       nak_q  <= reg_wdata[0];
      end
   end

   assign ten_bit = mode_q[0];
   assign irm_en  = mode_q[2];
   assign gc_en   = mode_q[3];
   assign own_hi  = mode_q[5:4];

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == REG_AW'(OFS_MODE))   reg_rdata = {{(BYTE_W-MODE_W){1'b0}}, mode_q};
      if (reg_addr == REG_AW'(OFS_OWN))    reg_rdata = own_lo;
      if (reg_addr == REG_AW'(OFS_CTRL))   reg_rdata = {{(BYTE_W-1){1'b0}}, nak_q};
      if (reg_addr == REG_AW'(OFS_STATUS)) reg_rdata = {4'd0, sts_hold, sts_rd, sts_gca, sts_match};
      if (reg_addr == REG_AW'(OFS_RXDATA)) reg_rdata = rx_last;
   end
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
   import i2c_tgt_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int REG_AW      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_oe,
   output logic              sda_oe,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [BYTE_W-1:0] reg_wdata,
   output logic [BYTE_W-1:0] reg_rdata,
   output logic              rx_irq
);
   localparam logic [BIT_CNT_W-1:0] FULL = BIT_CNT_W'(BYTE_W);

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic ten_bit, irm_en, gc_en, nak_q, ctrl_wr;
   logic [1:0]        own_hi;
   logic [BYTE_W-1:0] own_lo;

   tgt_state_t           st;
   phase_t               ph, nxt_ph_q;
   logic [BIT_CNT_W-1:0] cnt;
   logic [BYTE_W-1:0]    shreg, rx_q;
   logic                 sda_q, ack_ok, ack_hi, end_rd, irq_q;
   logic                 sts_match, sts_gca, sts_rd;
   addr_dec_t            dec;
   logic                 in_hold, in_ackdrv;

   i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   i2c_tgt_addr_match u_match (
      .rx_byte(shreg), .ph(ph), .ten_bit(ten_bit), .gc_en(gc_en),
      .own_hi(own_hi), .own_lo(own_lo), .dec(dec)
   );

   i2c_tgt_regs #(.REG_AW(REG_AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sts_match(sts_match), .sts_gca(sts_gca), .sts_rd(sts_rd),
      .sts_hold(in_hold), .rx_last(rx_q),
      .ten_bit(ten_bit), .irm_en(irm_en), .gc_en(gc_en), .own_hi(own_hi),
      .own_lo(own_lo), .nak_q(nak_q), .ctrl_wr(ctrl_wr)
   );

   assign in_hold   = (st == ST_HOLD);
   assign in_ackdrv = (st == ST_REL) || (st == ST_ACK);
   assign scl_oe    = (st == ST_HOLD) || (st == ST_REL);
   assign sda_oe    = sda_q;
   assign rx_irq    = irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         ph        <= PH_A1;
         nxt_ph_q  <= PH_A1;
         cnt       <= '0;
         shreg     <= '0;
         rx_q      <= '0;
         sda_q     <= 1'b0;
         ack_ok    <= 1'b0;
         ack_hi    <= 1'b0;
         end_rd    <= 1'b0;
         irq_q     <= 1'b0;
         sts_match <= 1'b0;
         sts_gca   <= 1'b0;
         sts_rd    <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (stop_det) begin
            st    <= ST_IDLE;
            sda_q <= 1'b0;
         end else if (start_det) begin
            st    <= ST_SHIFT;
            ph    <= PH_A1;
            cnt   <= '0;
            sda_q <= 1'b0;
         end else begin
            unique case (st)
               ST_SHIFT: begin
                  if (scl_rise && cnt < FULL) begin
                     shreg <= {shreg[BYTE_W-2:0], sda_s};
                     cnt   <= cnt + 1'b1;
                  end else if (scl_fall && cnt == FULL) begin
                     rx_q     <= shreg;
                     nxt_ph_q <= dec.nxt;
                     end_rd   <= dec.rd;
                     ack_hi   <= 1'b0;
                     if (ph != PH_DAT) begin
                        sts_match <= dec.hit;
                        sts_gca   <= dec.gc;
                        sts_rd    <= dec.rd;
                     end
                     if (irm_en) begin
                        st    <= ST_HOLD;
                        irq_q <= 1'b1;
                     end else if (dec.hit && !nak_q) begin
                        st     <= ST_ACK;
                        sda_q  <= 1'b1;
                        ack_ok <= 1'b1;
                        irq_q  <= (ph == PH_DAT);
                     end else begin
                        st <= ST_SKIP;
                     end
                  end
               end
               ST_HOLD: begin
                  if (ctrl_wr) begin
                     sda_q  <= ~reg_wdata[0];
                     ack_ok <= ~reg_wdata[0];
                     st     <= ST_REL;
                  end
               end
               ST_REL: st <= ST_ACK;
               ST_ACK: begin
                  if (scl_rise) begin
                     ack_hi <= 1'b1;
                  end else if (scl_fall && ack_hi) begin
                     sda_q <= 1'b0;
                     if (ack_ok && !end_rd) begin
                        st  <= ST_SHIFT;
                        ph  <= nxt_ph_q;
                        cnt <= '0;
                     end else begin
                        st <= ST_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic scl_oe,
   input logic sda_oe,
   input logic in_hold,
   input logic in_ackdrv,
   input logic ctrl_wr,
   input logic start_det,
   input logic stop_det
);
   // R11: SDA enable moves only while the SCL line is low
   a_r11_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !$past(scl_i));

   // R11: hold released by the second edge after the host write
   a_r11_release_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (in_hold && ctrl_wr && !start_det && !stop_det) |=> ##1 !scl_oe);

   // R9: hold persists without a host write
   a_r9_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (in_hold && !ctrl_wr && !start_det && !stop_det) |=> scl_oe);

   // R12: START or STOP releases both lines
   a_r12_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det || stop_det) |=> (!scl_oe && !sda_oe));

   // R2: SDA is pulled only in the acknowledge slot
   a_r2_sda_only_ack: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe |-> in_ackdrv);
endmodule

bind i2c_tgt_ctrl i2c_tgt_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
   .in_hold(in_hold), .in_ackdrv(in_ackdrv), .ctrl_wr(ctrl_wr),
   .start_det(start_det), .stop_det(stop_det)
);

// File: tb/i2c_tgt_ctrl_tb_top.sv
`timescale 1ns/1ps
module i2c_tgt_ctrl_tb_top;
   localparam int H = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1, m_sda = 1'b1;
   logic scl_oe, sda_oe, rx_irq, reg_wr = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0, reg_rdata;
   logic scl_line, sda_line;
   int total = 0, bad = 0, irq_cnt = 0;

   always #10 clk = ~clk;

   assign scl_line = m_scl & ~scl_oe;
   assign sda_line = m_sda & ~sda_oe;

   i2c_tgt_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_irq(rx_irq)
   );

   always @(posedge clk) if (rst_n && rx_irq) irq_cnt++;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); reg_addr = a; #1 d = reg_rdata;
   endtask

   task automatic i2c_start();
      m_sda = 1'b1; wait_n(H);
      m_scl = 1'b1; wait (scl_line); wait_n(H);
      m_sda = 1'b0; wait_n(H);
      m_scl = 1'b0; wait_n(H);
   endtask

   task automatic i2c_stop();
      m_sda = 1'b0; wait_n(H);
      m_scl = 1'b1; wait (scl_line); wait_n(H);
      m_sda = 1'b1; wait_n(H);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         m_sda = b[i]; wait_n(H);
         m_scl = 1'b1; wait (scl_line); wait_n(H);
         m_scl = 1'b0; wait_n(2);
      end
      m_sda = 1'b1;
   endtask

   task automatic ack_clock(output logic a);
      wait_n(H);
      m_scl = 1'b1; wait (scl_line); wait_n(H);
      a = ~sda_line;
      m_scl = 1'b0; wait_n(H);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic a);
      send_bits(b, 8);
      ack_clock(a);
   endtask

   // host answers a held byte; reports the ack seen in the slot
   task automatic irm_answer(input logic nakv, output logic a);
      m_scl = 1'b1; wait_n(30);
      chk("R9 scl held while host silent", scl_line, 1'b0);
      wr_reg(3'd2, {7'd0, nakv});
      @(negedge clk);
      chk("R11 scl released after write", scl_oe, 1'b0);
      wait (scl_line); wait_n(H);
      a = ~sda_line;
      m_scl = 1'b0; wait_n(H);
   endtask

   function automatic logic exp_a1(input logic [7:0] b, input logic ten, input logic gce,
                                   input logic [1:0] hi, input logic [7:0] lo, input logic nak);
      if (nak) return 1'b0;
      if (b[7:1] == 7'd0) return gce;
      if (ten) return (b[7:3] == 5'b11110) && (b[2:1] == hi);
      return b[7:1] == lo[6:0];
   endfunction

   // directed 7-bit write: address then one data byte
   task automatic write7(input string req, input logic [7:0] a1, input logic exp_ack,
                         input logic [7:0] d);
      logic a;
      logic [7:0] r;
      int i0;
      i0 = irq_cnt;
      i2c_start();
      send_byte(a1, a);
      chk({req, " address ack"}, a, exp_ack);
      send_byte(d, a);
      chk({req, " data ack"}, a, exp_ack);
      if (exp_ack) begin
         rd_reg(3'd4, r);
         chk({req, " rxdata"}, r, d);
      end
      i2c_stop();
      chk({req, " irq count"}, irq_cnt - i0, exp_ack ? 1 : 0);
   endtask

   initial begin
      logic [7:0] r, b1, b2, d;
      logic a, e, ten, so, gce, nak, rw, isgc, go;
      logic [1:0] hi;
      logic [7:0] lo;
      int i0, ei;

      wait_n(5);
      rst_n = 1'b1;
      wait_n(3);
      // R1 reset state
      rd_reg(3'd0, r); chk("R1 mode reset", r, 8'h00);
      rd_reg(3'd1, r); chk("R1 own reset", r, 8'h00);
      rd_reg(3'd2, r); chk("R1 ctrl reset", r, 8'h00);
      rd_reg(3'd3, r); chk("R1 status reset", r, 8'h00);
      chk("R1 outputs idle", {scl_oe, sda_oe, rx_irq}, 3'b000);

      // R2 target-only 7-bit, own 0x5A
      wr_reg(3'd0, 8'h02);
      wr_reg(3'd1, 8'h5A);
      write7("R2", 8'hB4, 1'b1, 8'h3C);
      rd_reg(3'd3, r); chk("R2 status match", r, 8'h01);
      // R3 wrong address
      write7("R3", 8'hB6, 1'b0, 8'h11);
      // R4 NAK bit set
      wr_reg(3'd2, 8'h01);
      write7("R4", 8'hB4, 1'b0, 8'h22);
      wr_reg(3'd2, 8'h00);
      // R6 upper bits ignored in 7-bit mode
      wr_reg(3'd0, 8'h32);
      write7("R6", 8'hB4, 1'b1, 8'h5E);
      // R13 master-capable 7-bit mode
      wr_reg(3'd0, 8'h00);
      write7("R13", 8'hB4, 1'b1, 8'h6D);

      // R5 10-bit, hi=2, lo=0xA7
      wr_reg(3'd0, 8'h23);
      wr_reg(3'd1, 8'hA7);
      i0 = irq_cnt;
      i2c_start();
      send_byte(8'hF4, a); chk("R5 10-bit header ack", a, 1'b1);
      send_byte(8'hA7, a); chk("R5 10-bit low byte ack", a, 1'b1);
      send_byte(8'h99, a); chk("R5 10-bit data ack", a, 1'b1);
      i2c_stop();
      chk("R5 irq count", irq_cnt - i0, 1);
      i2c_start();
      send_byte(8'hF2, a); chk("R5 header wrong upper bits", a, 1'b0);
      i2c_stop();
      i2c_start();
      send_byte(8'hF4, a);
      send_byte(8'hA6, a); chk("R5 wrong low byte", a, 1'b0);
      i2c_stop();

      // R7 general call
      wr_reg(3'd0, 8'h02);
      wr_reg(3'd1, 8'h5A);
      write7("R7 gc disabled", 8'h00, 1'b0, 8'h01);
      wr_reg(3'd0, 8'h0A);
      write7("R7 gc enabled", 8'h00, 1'b1, 8'h02);
      rd_reg(3'd3, r); chk("R7 gca flag", r, 8'h03);
      write7("R7 start byte", 8'h01, 1'b1, 8'h03);
      write7("R7 own after gc", 8'hB4, 1'b1, 8'h04);
      rd_reg(3'd3, r); chk("R7 gca clear on own", r, 8'h01);

      // R8 read direction
      i2c_start();
      send_byte(8'hB5, a); chk("R8 read address ack", a, 1'b1);
      rd_reg(3'd3, r); chk("R8 rd flag", r, 8'h05);
      ei = 0;
      for (int i = 0; i < 8; i++) begin
         wait_n(H); m_scl = 1'b1; wait_n(H);
         if (!sda_line) ei++;
         m_scl = 1'b0; wait_n(2);
      end
      chk("R8 sda released in read", ei, 0);
      i2c_stop();

      // R9 R10 R11 interactive mode
      wr_reg(3'd0, 8'h06);
      i0 = irq_cnt;
      i2c_start();
      send_bits(8'hB4, 8); wait_n(H);
      chk("R9 scl_oe on address", scl_oe, 1'b1);
      chk("R9 irq on address", irq_cnt - i0, 1);
      rd_reg(3'd3, r); chk("R9 hold status", r[3], 1'b1);
      irm_answer(1'b0, a); chk("R10 host ack on address", a, 1'b1);
      send_bits(8'h77, 8); wait_n(H);
      chk("R9 scl_oe on data", scl_oe, 1'b1);
      chk("R9 irq on data", irq_cnt - i0, 2);
      irm_answer(1'b1, a); chk("R10 host nak on data", a, 1'b0);
      i2c_stop();
      rd_reg(3'd4, r); chk("R9 rxdata in interactive", r, 8'h77);
      wr_reg(3'd2, 8'h00);

      // R12 aborted bytes
      wr_reg(3'd0, 8'h02);
      i0 = irq_cnt;
      i2c_start();
      send_bits(8'hB4, 4);
      i2c_start();
      send_byte(8'hB4, a); chk("R12 address after repeated start", a, 1'b1);
      send_bits(8'h55, 5);
      i2c_stop();
      wait_n(4);
      chk("R12 lines released after stop", {scl_oe, sda_oe}, 2'b00);
      chk("R12 no irq from cut byte", irq_cnt - i0, 0);

      // random transfers in automatic mode
      void'($urandom(32'd2024));
      for (int t = 0; t < 30; t++) begin
         ten = 1'($urandom % 2); so = 1'($urandom % 2); gce = 1'($urandom % 2);
         hi = 2'($urandom % 4); lo = 8'($urandom % 256); nak = ($urandom % 4 == 0);
         rw = ($urandom % 4 == 0);
         wr_reg(3'd0, {2'b00, hi, gce, 1'b0, so, ten});
         wr_reg(3'd1, lo);
         wr_reg(3'd2, {7'd0, nak});
         case ($urandom % 4)
            0, 1: b1 = ten ? {5'b11110, hi, rw} : {lo[6:0], rw};
            2: b1 = {7'd0, 1'($urandom % 2)};
            default: b1 = 8'($urandom % 256);
         endcase
         i0 = irq_cnt; ei = 0;
         e = exp_a1(b1, ten, gce, hi, lo, nak);
         isgc = (b1[7:1] == 7'd0);
         i2c_start();
         send_byte(b1, a);
         chk(ten ? "R5 random first byte" : "R2 R3 random first byte", a, e);
         if (e && !(b1[0] && !isgc)) begin
            go = 1'b1;
            if (ten && b1[7:3] == 5'b11110 && !b1[0] && !isgc) begin
               b2 = ($urandom % 3 == 0) ? 8'($urandom % 256) : lo;
               send_byte(b2, a);
               go = (b2 == lo);
               chk("R5 random second byte", a, go);
            end
            if (go) begin
               for (int k = 0; k < 1 + int'($urandom % 2); k++) begin
                  d = 8'($urandom % 256);
                  send_byte(d, a);
                  chk("R2 random data ack", a, 1'b1);
                  rd_reg(3'd4, r);
                  chk("R2 random rxdata", r, d);
                  ei++;
               end
            end
         end
         i2c_stop();
         chk("R2 R3 random irq count", irq_cnt - i0, ei);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule